// File: doc/BRIEF.md
# Calibration Readout Mode Controller

This block sits in the command path of a DDR3-style DRAM model and manages the calibration readout mode. It receives one decoded command per clock, together with the open/idle state of every bank and a flag saying the precharge time has elapsed. It keeps track of whether the readout mode is on and which pattern location was chosen when the mode was entered. While the mode is off, reads go to the memory array and read-with-auto-precharge also requests the precharge. While the mode is on, reads are answered from a fixed training pattern instead, and every command other than a read, a mode exit or a reset is flagged and discarded.

Pattern data comes out as a burst of single-data-rate beats with a valid strobe, after a fixed read latency. A sticky error flag holds the opcode of the first rejected command until a RESET command or the hardware reset clears it. Reads in the mode are expected to be at least one burst length apart. A new read that arrives while a burst is still running restarts the burst.

Top module: `calReadoutTop`

## Requirements
- R1: An MRS command (opcode 1) with `mrSel`=3 and `mrBits[2]`=1, issued while the mode is off, all `bankOpen` bits are 0 and `trpDone` is 1, sets `modeOn` on the following cycle and selects location `mrBits[1:0]`.
- R2: While the mode is off, RD (opcode 2) pulses `arrayRd` for one cycle, and RDA (opcode 3) pulses both `arrayRd` and `arrayAutoPre`. An MRS to register 3 with `mrBits[2]`=0 is accepted with no error whatever `mrBits[1:0]` holds, and the mode stays off.
- R3: An enabling MRS issued while any bank is open or `trpDone` is 0 pulses `illegal` and leaves the mode off.
- R4: While the mode is on, RD and RDA do not pulse `arrayRd` or `arrayAutoPre`. Each of them starts a pattern burst.
- R5: For location 0, beat k of the burst is all zeros on every lane when k is even and all ones when k is odd. Locations 1 to 3 give all zeros. `dqOut` is zero whenever `dqValid` is low.
- R6: The first beat appears RD_LAT clock edges after the edge that samples the read, and `dqValid` stays high for exactly BURST_LEN consecutive cycles.
- R7: While the mode is on, every other command pulses `illegal` on the next cycle and leaves `modeOn` unchanged. This covers WR 4, PRE 5, ACT 6, REF 7, power-down entry 8, self-refresh entry 9, MRS to a register other than 3, and MRS to register 3 with `mrBits[2]`=1. NOP (opcode 0) is never flagged.
- R8: An MRS to register 3 with `mrBits[2]`=0 while the mode is on clears `modeOn` on the next cycle. Later reads go to the array again.
- R9: A RESET command (opcode 10) in any state clears `modeOn` and `errSticky` and cancels pending or running pattern beats.
- R10: The first illegal command sets `errSticky` and loads its opcode into `errOp`. Later illegal commands leave `errOp` unchanged until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 4 | Command opcode |
| mrSel | input | 2 | Mode register addressed by MRS |
| mrBits | input | 3 | MRS bits: [2] mode enable, [1:0] location |
| bankOpen | input | NUM_BANKS | One bit per bank, 1 = row open |
| trpDone | input | 1 | Precharge time elapsed |
| modeOn | output | 1 | Readout mode active |
| arrayRd | output | 1 | Read forwarded to the array |
| arrayAutoPre | output | 1 | Auto-precharge forwarded to the array |
| illegal | output | 1 | Command rejected (one-cycle pulse) |
| errSticky | output | 1 | An illegal command was seen since the last reset |
| errOp | output | 4 | Opcode of the first illegal command |
| dqOut | output | DQ_W | Pattern data lanes |
| dqValid | output | 1 | Pattern beat valid |

## Verification
The checker watches on every cycle that commands map to the right state change: legal entry, gated entry, exit, rejection inside the mode, suppression of array reads, reset clearing, the sticky error holding its opcode, and quiet data lanes outside a burst. Only the bench scenarios can show the beat-by-beat pattern for each location, the exact latency and length of the burst, and the cancelling of a burst already in flight by a RESET. They do this through a scoreboard that holds the expected beats together with their cycle numbers.

// File: rtl/calReadoutPkg.sv
package calReadoutPkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_MRS = 4'd1,
    OP_RD  = 4'd2,
    OP_RDA = 4'd3,
    OP_WR  = 4'd4,
    OP_PRE = 4'd5,
    OP_ACT = 4'd6,
    OP_REF = 4'd7,
    OP_PDE = 4'd8,
    OP_SRE = 4'd9,
    OP_RST = 4'd10
  } cmdOp_e;

  localparam logic [1:0] MR_READOUT = 2'd3;

  typedef struct packed {
    logic       fire;
    logic [1:0] loc;
    logic       flush;
  } patStrobe_t;
endpackage

// File: rtl/calReadoutCtl.sv
module calReadoutCtl
  import calReadoutPkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdValid,
  input  logic [3:0]           cmdOp,
  input  logic [1:0]           mrSel,
  input  logic [2:0]           mrBits,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 trpDone,
  output logic                 modeOn,
  output logic                 arrayRd,
  output logic                 arrayAutoPre,
  output logic                 illegal,
  output logic                 errSticky,
  output logic [3:0]           errOp,
  output patStrobe_t           patStb
);
  cmdOp_e     op;
  logic       isRst, isRead, isMr3, banksIdle;
  logic       nextMode, bad, fire, aRd, aPre;
  logic [1:0] locQ, nextLoc;

  assign op        = cmdOp_e'(cmdOp);
  assign isRst     = cmdValid && (op == OP_RST);
  assign isRead    = cmdValid && (op == OP_RD || op == OP_RDA);
  assign isMr3     = cmdValid && (op == OP_MRS) && (mrSel == MR_READOUT);
  assign banksIdle = ~|bankOpen && trpDone;

  always_comb begin
    nextMode = modeOn;
    nextLoc  = locQ;
    bad      = 1'b0;
    fire     = 1'b0;
    aRd      = 1'b0;
    aPre     = 1'b0;
    if (isRst) begin
      nextMode = 1'b0;
    end else if (cmdValid) begin
      if (!modeOn) begin
        if (isMr3 && mrBits[2]) begin
          if (banksIdle) begin
            nextMode = 1'b1;
            nextLoc  = mrBits[1:0];
          end else begin
            bad = 1'b1;
          end
        end
        if (op == OP_RD || op == OP_RDA) aRd = 1'b1;
        if (op == OP_RDA) aPre = 1'b1;
      end else begin
        if (isRead) begin
          fire = 1'b1;
        end else if (isMr3 && !mrBits[2]) begin
          nextMode = 1'b0;
        end else if (op != OP_NOP) begin
          bad = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeOn       <= 1'b0;
      locQ         <= 2'd0;
      arrayRd      <= 1'b0;
      arrayAutoPre <= 1'b0;
      illegal      <= 1'b0;
      errSticky    <= 1'b0;
      errOp        <= 4'd0;
    end else begin
      modeOn       <= nextMode;
      locQ         <= nextLoc;
      arrayRd      <= aRd;
      arrayAutoPre <= aPre;
      illegal      <= bad;
      if (isRst) begin
        errSticky <= 1'b0;
        errOp     <= 4'd0;
      end else if (bad && !errSticky) begin
        errSticky <= 1'b1;
        errOp     <= cmdOp;
      end
    end
  end

  assign patStb.fire  = fire;
  assign patStb.loc   = locQ;
  assign patStb.flush = isRst;
endmodule

// File: rtl/calReadoutDp.sv
module calReadoutDp
  import calReadoutPkg::*;
#(
  parameter int DQ_W      = 8,
  parameter int RD_LAT    = 4,
  parameter int BURST_LEN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  patStrobe_t      patStb,
  output logic [DQ_W-1:0] dqOut,
  output logic            dqValid
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic [RD_LAT-1:0] pendV;
  logic [1:0]        pendLoc [RD_LAT];
  logic [BEAT_W-1:0] beatCnt;
  logic [1:0]        burstLoc;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendV <= '0;
      for (int i = 0; i < RD_LAT; i++) pendLoc[i] <= 2'd0;
    end else if (patStb.flush) begin
      pendV <= '0;
    end else begin
      pendV[0]   <= patStb.fire;
      pendLoc[0] <= patStb.loc;
      for (int i = 1; i < RD_LAT; i++) begin
        pendV[i]   <= pendV[i-1];
        pendLoc[i] <= pendLoc[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beatCnt  <= '0;
      burstLoc <= 2'd0;
    end else if (patStb.flush) begin
      active  <= 1'b0;
      beatCnt <= '0;
    end else if (pendV[RD_LAT-1]) begin
      active   <= 1'b1;
      beatCnt  <= '0;
      burstLoc <= pendLoc[RD_LAT-1];
    end else if (active) begin
      if (beatCnt == LAST_BEAT) begin
        active  <= 1'b0;
        beatCnt <= '0;
      end else begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  assign dqValid = active;
  assign dqOut   = (active && burstLoc == 2'd0 && beatCnt[0]) ? {DQ_W{1'b1}} : {DQ_W{1'b0}};
endmodule

// File: rtl/calReadoutTop.sv
module calReadoutTop
  import calReadoutPkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int DQ_W      = 8,
  parameter int RD_LAT    = 4,
  parameter int BURST_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdValid,
  input  logic [3:0]           cmdOp,
  input  logic [1:0]           mrSel,
  input  logic [2:0]           mrBits,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 trpDone,
  output logic                 modeOn,
  output logic                 arrayRd,
  output logic                 arrayAutoPre,
  output logic                 illegal,
  output logic                 errSticky,
  output logic [3:0]           errOp,
  output logic [DQ_W-1:0]      dqOut,
  output logic                 dqValid
);
  patStrobe_t patStb;

  calReadoutCtl #(.NUM_BANKS(NUM_BANKS)) i_ctl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .mrSel(mrSel), .mrBits(mrBits), .bankOpen(bankOpen), .trpDone(trpDone),
    .modeOn(modeOn), .arrayRd(arrayRd), .arrayAutoPre(arrayAutoPre),
    .illegal(illegal), .errSticky(errSticky), .errOp(errOp), .patStb(patStb)
  );

  calReadoutDp #(.DQ_W(DQ_W), .RD_LAT(RD_LAT), .BURST_LEN(BURST_LEN)) i_dp (
    .clk(clk), .rst_n(rst_n), .patStb(patStb), .dqOut(dqOut), .dqValid(dqValid)
  );
endmodule

// File: rtl/calReadoutChk.sv
module calReadoutChk #(
  parameter int NUM_BANKS = 8,
  parameter int DQ_W      = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmdValid,
  input logic [3:0]           cmdOp,
  input logic [1:0]           mrSel,
  input logic [2:0]           mrBits,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 trpDone,
  input logic                 modeOn,
  input logic                 arrayRd,
  input logic                 arrayAutoPre,
  input logic                 illegal,
  input logic                 errSticky,
  input logic [3:0]           errOp,
  input logic [DQ_W-1:0]      dqOut,
  input logic                 dqValid
);
  logic mrsOn, mrsOff, readCmd, rstCmd, otherCmd;
  assign mrsOn    = cmdValid && cmdOp == 4'd1 && mrSel == 2'd3 && mrBits[2];
  assign mrsOff   = cmdValid && cmdOp == 4'd1 && mrSel == 2'd3 && !mrBits[2];
  assign readCmd  = cmdValid && (cmdOp == 4'd2 || cmdOp == 4'd3);
  assign rstCmd   = cmdValid && cmdOp == 4'd10;
  assign otherCmd = cmdValid && cmdOp >= 4'd4 && cmdOp <= 4'd9;

  p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeOn && mrsOn && bankOpen == '0 && trpDone) |=> modeOn);

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeOn && mrsOn && (bankOpen != '0 || !trpDone)) |=> (illegal && !modeOn));

  p_noarray_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOn && readCmd) |=> (!arrayRd && !arrayAutoPre));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dqValid |-> dqOut == '0);

  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOn && otherCmd) |=> (illegal && modeOn));

  p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOn && mrsOff) |=> !modeOn);

  p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rstCmd |=> (!modeOn && !errSticky && !dqValid));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (errSticky && !rstCmd) |=> (errSticky && $stable(errOp)));
endmodule

bind calReadoutTop calReadoutChk #(.NUM_BANKS(NUM_BANKS), .DQ_W(DQ_W)) i_chk (.*);

// File: tb/test_calReadoutTop.sv
module test_calReadoutTop;
  localparam int NB = 8, DW = 8, LAT = 4, BL = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cmdValid = 1'b0;
  logic [3:0]    cmdOp = 4'd0;
  logic [1:0]    mrSel = 2'd0;
  logic [2:0]    mrBits = 3'd0;
  logic [NB-1:0] bankOpen = '0;
  logic          trpDone = 1'b1;
  logic          modeOn, arrayRd, arrayAutoPre, illegal, errSticky, dqValid;
  logic [3:0]    errOp;
  logic [DW-1:0] dqOut;

  int total = 0, bad = 0, cycCnt = 0, beatsSeen = 0;
  bit finished = 0;

  typedef struct { int cyc; logic [DW-1:0] data; } beat_t;
  beat_t expQ[$];

  calReadoutTop #(.NUM_BANKS(NB), .DQ_W(DW), .RD_LAT(LAT), .BURST_LEN(BL)) i_calReadoutTop (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dqValid) begin
      beat_t b;
      beatsSeen++;
      if (expQ.size() == 0) begin
        chk(0, "R6", "unexpected beat at cycle", cycCnt, -1);
      end else begin
        b = expQ.pop_front();
        chk(dqOut == b.data, "R5", "beat data", int'(dqOut), int'(b.data));
        chk(cycCnt == b.cyc, "R6", "beat cycle", cycCnt, b.cyc);
      end
    end
  end

  task automatic issue(input logic [3:0] op, input logic [1:0] mr, input logic [2:0] bits,
                       input bit expPat, input logic [1:0] loc);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; mrSel = mr; mrBits = bits;
    if (expPat)
      for (int k = 0; k < BL; k++) begin
        beat_t b;
        b.cyc  = cycCnt + 1 + LAT + k;
        b.data = (loc == 2'd0 && (k % 2) == 1) ? {DW{1'b1}} : {DW{1'b0}};
        expQ.push_back(b);
      end
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 4'd0; mrSel = 2'd0; mrBits = 3'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "R6", "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!modeOn && !errSticky && !dqValid && !illegal, "R9", "reset state", modeOn, 0);

    // R2: normal reads to array
    issue(4'd2, 2'd0, 3'd0, 0, 2'd0);
    chk(arrayRd && !arrayAutoPre, "R2", "RD to array", {arrayRd, arrayAutoPre}, 2);
    issue(4'd3, 2'd0, 3'd0, 0, 2'd0);
    chk(arrayRd && arrayAutoPre, "R2", "RDA to array", {arrayRd, arrayAutoPre}, 3);
    issue(4'd1, 2'd3, 3'b011, 0, 2'd0);
    chk(!illegal && !modeOn, "R2", "MR3 A2=0 ignores loc", {illegal, modeOn}, 0);

    // R3: gated entry, open bank
    bankOpen = 8'b0000_0100;
    issue(4'd1, 2'd3, 3'b100, 0, 2'd0);
    chk(illegal && !modeOn, "R3", "entry with bank open", {illegal, modeOn}, 2);
    chk(errSticky && errOp == 4'd1, "R10", "sticky opcode MRS", int'(errOp), 1);
    bankOpen = '0; trpDone = 1'b0;
    issue(4'd1, 2'd3, 3'b100, 0, 2'd0);
    chk(illegal && !modeOn, "R3", "entry before tRP", {illegal, modeOn}, 2);
    trpDone = 1'b1;
    issue(4'd10, 2'd0, 3'd0, 0, 2'd0);
    chk(!errSticky && !modeOn, "R9", "RESET clears sticky", errSticky, 0);

    // R1: legal entry, location 0
    issue(4'd1, 2'd3, 3'b100, 0, 2'd0);
    chk(modeOn && !illegal, "R1", "mode entered", modeOn, 1);

    // R4, R5, R6: reads redirected
    issue(4'd2, 2'd0, 3'd0, 1, 2'd0);
    chk(!arrayRd, "R4", "RD not to array", arrayRd, 0);
    idle(12);
    issue(4'd3, 2'd0, 3'd0, 1, 2'd0);
    chk(!arrayRd && !arrayAutoPre, "R4", "RDA no auto-precharge", {arrayRd, arrayAutoPre}, 0);
    idle(12);
    chk(expQ.size() == 0 && beatsSeen == 2 * BL, "R6", "burst length", beatsSeen, 2 * BL);

    // R7, R10: rejected commands in mode
    issue(4'd5, 2'd0, 3'd0, 0, 2'd0);
    chk(illegal && modeOn, "R7", "PRE rejected", {illegal, modeOn}, 3);
    chk(errSticky && errOp == 4'd5, "R10", "first illegal opcode", int'(errOp), 5);
    issue(4'd7, 2'd0, 3'd0, 0, 2'd0);
    chk(illegal && modeOn, "R7", "REF rejected", {illegal, modeOn}, 3);
    issue(4'd8, 2'd0, 3'd0, 0, 2'd0);
    chk(illegal && modeOn, "R7", "power-down rejected", {illegal, modeOn}, 3);
    issue(4'd9, 2'd0, 3'd0, 0, 2'd0);
    chk(illegal && modeOn, "R7", "self-refresh rejected", {illegal, modeOn}, 3);
    issue(4'd1, 2'd1, 3'b000, 0, 2'd0);
    chk(illegal && modeOn, "R7", "MRS to MR1 rejected", {illegal, modeOn}, 3);
    issue(4'd1, 2'd3, 3'b110, 0, 2'd0);
    chk(illegal && modeOn, "R7", "MR3 re-enable rejected", {illegal, modeOn}, 3);
    issue(4'd0, 2'd0, 3'd0, 0, 2'd0);
    chk(!illegal && modeOn, "R7", "NOP accepted", illegal, 0);
    chk(errOp == 4'd5, "R10", "opcode held", int'(errOp), 5);
    // location 0 still in effect after the rejected re-enable
    issue(4'd2, 2'd0, 3'd0, 1, 2'd0);
    idle(12);

    // R9: RESET cancels burst in flight
    issue(4'd2, 2'd0, 3'd0, 0, 2'd0);
    issue(4'd10, 2'd0, 3'd0, 0, 2'd0);
    chk(!modeOn && !errSticky, "R9", "RESET exits mode", {modeOn, errSticky}, 0);
    beatsSeen = 0;
    idle(14);
    chk(beatsSeen == 0, "R9", "burst cancelled", beatsSeen, 0);
    issue(4'd2, 2'd0, 3'd0, 0, 2'd0);
    chk(arrayRd, "R9", "RD to array after RESET", arrayRd, 1);

    // R5: reserved location gives zeros
    issue(4'd1, 2'd3, 3'b110, 0, 2'd0);
    chk(modeOn, "R1", "entry location 2", modeOn, 1);
    issue(4'd2, 2'd0, 3'd0, 1, 2'd2);
    idle(12);

    // R8: exit
    issue(4'd1, 2'd3, 3'b001, 0, 2'd0);
    chk(!modeOn && !illegal, "R8", "mode exited", {modeOn, illegal}, 0);
    beatsSeen = 0;
    issue(4'd3, 2'd0, 3'd0, 0, 2'd0);
    chk(arrayRd && arrayAutoPre, "R8", "RDA to array after exit", {arrayRd, arrayAutoPre}, 3);
    idle(12);
    chk(beatsSeen == 0 && expQ.size() == 0, "R8", "no pattern after exit", beatsSeen, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule